// File: doc/BRIEF.md
# Packed Colour Palette with Component Expansion

This block holds a 256-colour lookup table that software fills over a 32-bit register bus and that a pixel pipeline queries one index per clock. Each 32-bit bus word packs two 16-bit colour entries, so the whole table fits in 128 word registers inside a byte-addressed window. The raw words are kept exactly as written and read back unchanged.

On the pixel side an 8-bit index selects one entry. Its three 5-bit colour fields are widened to 8 bits by appending three zero bits, and the result leaves the block registered one clock later, together with a valid strobe. The top bit of each entry is an intensity flag that the colour path ignores.

Top module: `palette_lut`

## Requirements
- R1: After a synchronous active-low reset every table word reads as zero and both `bus_rd_valid` and `pix_out_valid` are low.
- R2: A write at byte address 0x200 + 4·n (n = 0..127, address bits 1:0 ignored) stores the full 32-bit word n; a read of that address returns the last written word on `bus_rd_data` one clock after `bus_rd_en`, with `bus_rd_valid` high in that cycle only.
- R3: Writes to addresses below 0x200 or above 0x3FF change no table word; reads of such addresses return zero with `bus_rd_valid` high.
- R4: Pixel index 2n selects bits 15:0 of word n and index 2n+1 selects bits 31:16.
- R5: Within a 16-bit entry, bits 4:0 are red, bits 9:5 green and bits 14:10 blue; each output component equals its field shifted left by three, low three bits zero.
- R6: Entry bit 15 has no effect on the red, green or blue outputs.
- R7: The colour outputs and `pix_out_valid` update one clock after `pix_valid` and `pix_index` are presented; `pix_out_valid` is low one clock after a cycle without `pix_valid`.
- R8: A lookup of an entry written in the same cycle returns the colour held before that write.
- R9: A bus read of a word written in the same cycle returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_addr | input | 12 | Write byte address |
| bus_wr_data | input | 32 | Write data, two packed entries |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_addr | input | 12 | Read byte address |
| bus_rd_data | output | 32 | Read data, registered |
| bus_rd_valid | output | 1 | Read data valid |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Palette entry index |
| pix_red | output | 8 | Expanded red |
| pix_green | output | 8 | Expanded green |
| pix_blue | output | 8 | Expanded blue |
| pix_out_valid | output | 1 | Colour outputs valid |

## Verification
Both results of this block are due exactly one clock after their request: the bus read data and the expanded colour each pass through a single register stage, and a write becomes visible to either path from the following cycle. The bench drives every request on a falling edge, computes the expected read word and colour from its model before applying that cycle's write, and compares the outputs on the next falling edge, so same-cycle collisions expect the old contents. Every cycle is compared, including cycles with no request, where both valid strobes must be low.

// File: rtl/palette_pkg.sv
// Shared constants and helpers for the packed palette.
// Assumes 32-bit bus words carrying two 16-bit entries of three 5-bit fields.
package palette_pkg;
    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 16;
    localparam int FIELD_W = 5;
    localparam int COMP_W  = 8;
    localparam int N_COMP  = 3;

    // Widen a colour field to a display component by zero-filling the low bits.
    function automatic logic [COMP_W-1:0] widen(input logic [FIELD_W-1:0] f);
        return {f, {(COMP_W-FIELD_W){1'b0}}};
    endfunction
endpackage

// File: rtl/pal_addr_decode.sv
// Maps a byte address onto a word index inside the palette window.
// Assumes the window starts at BASE and spans WORDS aligned 32-bit words;
// address bits 1:0 are ignored.
module pal_addr_decode #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = WORDS * 4;
    logic [ADDR_W-1:0] rel;

    // Window test and word index extraction.
    always_comb begin
        rel = addr - ADDR_W'(BASE);
        hit = (int'(addr) >= BASE) && (int'(addr) < BASE + SPAN);
        idx = rel[IDX_W+1:2];
    end
endmodule

// File: rtl/pal_word_store.sv
// Raw word storage for the palette with one write port, one registered bus
// read port and one combinational lookup port. Reads see contents before a
// same-cycle write. Assumes synchronous active-low reset clears all words.
module pal_word_store #(
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS),
    localparam int W     = palette_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    input  logic             rd_hit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    output logic             rd_vld,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [W-1:0]     lk_word
);
    logic [W-1:0] mem [WORDS];

    // Word array: clear on reset, update on an in-window write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en && wr_hit) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Registered bus read; out-of-window reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld  <= rd_en;
            rd_data <= (rd_en && rd_hit) ? mem[rd_idx] : '0;
        end
    end

    // Lookup port reads the array as it stands before this edge.
    assign lk_word = mem[lk_idx];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit) |=> mem[$past(wr_idx)] == $past(wr_data));
    assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
    assert_oob_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> rd_data == '0);
endmodule

// File: rtl/pal_colour_expand.sv
// Selects one 16-bit entry from a packed word and widens its red, green and
// blue fields into registered 8-bit components. The top entry bit is unused.
module pal_colour_expand (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic        sel_hi,
    input  logic [palette_pkg::WORD_W-1:0] word,
    output logic [palette_pkg::COMP_W-1:0] comp [palette_pkg::N_COMP],
    output logic        out_vld
);
    import palette_pkg::*;
    logic [ENTRY_W-1:0] entry;

    // Half-word select: odd index takes the upper entry.
    assign entry = sel_hi ? word[WORD_W-1:ENTRY_W] : word[ENTRY_W-1:0];

    // Valid strobe follows the request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        // Register one widened component, holding it between requests.
        always_ff @(posedge clk) begin
            if (!rst_n)      comp[c] <= '0;
            else if (in_vld) comp[c] <= widen(entry[c*FIELD_W +: FIELD_W]);
        end

        assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> comp[c][COMP_W-FIELD_W-1:0] == '0);
    end

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
endmodule

// File: rtl/palette_lut.sv
// Top of the packed palette: bus write/read of raw words in a byte window and
// a one-cycle pixel lookup returning widened colour components.
// Assumes a single clock domain and synchronous active-low reset.
module palette_lut #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200,
    parameter int WORDS  = 128,
    localparam int IDX_W = $clog2(WORDS),
    localparam int PIX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_wr_addr,
    input  logic [31:0]       bus_wr_data,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_rd_addr,
    output logic [31:0]       bus_rd_data,
    output logic              bus_rd_valid,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_index,
    output logic [7:0]        pix_red,
    output logic [7:0]        pix_green,
    output logic [7:0]        pix_blue,
    output logic              pix_out_valid
);
    logic             wr_hit, rd_hit;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [31:0]      lk_word;
    logic [7:0]       comp [palette_pkg::N_COMP];

    pal_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_wdec (
        .addr(bus_wr_addr), .hit(wr_hit), .idx(wr_idx));
    pal_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_rdec (
        .addr(bus_rd_addr), .hit(rd_hit), .idx(rd_idx));

    pal_word_store #(.WORDS(WORDS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr_en), .wr_hit(wr_hit), .wr_idx(wr_idx), .wr_data(bus_wr_data),
        .rd_en(bus_rd_en), .rd_hit(rd_hit), .rd_idx(rd_idx),
        .rd_data(bus_rd_data), .rd_vld(bus_rd_valid),
        .lk_idx(pix_index[PIX_W-1:1]), .lk_word(lk_word));

    pal_colour_expand u_expand (
        .clk(clk), .rst_n(rst_n), .in_vld(pix_valid), .sel_hi(pix_index[0]),
        .word(lk_word), .comp(comp), .out_vld(pix_out_valid));

    // Component order on the outputs: field 0 red, 1 green, 2 blue.
    assign pix_red   = comp[0];
    assign pix_green = comp[1];
    assign pix_blue  = comp[2];
endmodule

// File: tb/sim_palette_lut.sv
module sim_palette_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pv = 1'b0;
    logic [11:0] wa = '0, ra = '0;
    logic [31:0] wd = '0;
    logic [7:0]  pidx = '0;
    logic [31:0] rdata;
    logic        rvld, ovld;
    logic [7:0]  red, grn, blu;

    int checks = 0, fails = 0;
    int model [128];
    logic [7:0] hold_r = 0, hold_g = 0, hold_b = 0;

    always #2 clk = ~clk;

    palette_lut u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(wr_en), .bus_wr_addr(wa), .bus_wr_data(wd),
        .bus_rd_en(rd_en), .bus_rd_addr(ra), .bus_rd_data(rdata), .bus_rd_valid(rvld),
        .pix_valid(pv), .pix_index(pidx),
        .pix_red(red), .pix_green(grn), .pix_blue(blu), .pix_out_valid(ovld));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(logic [11:0] a);
        return a >= 12'h200 && a < 12'h400;
    endfunction

    // One clock: inputs already set at a falling edge; model result, edge, compare.
    task automatic step(string tag);
        logic [31:0] e_rd, w;
        logic [15:0] h;
        logic        e_rv, e_ov;
        e_rv = rd_en;
        e_rd = (rd_en && in_win(ra)) ? model[(ra - 12'h200) >> 2] : 32'h0;
        e_ov = pv;
        if (pv) begin
            w = model[pidx >> 1];
            h = pidx[0] ? w[31:16] : w[15:0];
            hold_r = {h[4:0], 3'b000};
            hold_g = {h[9:5], 3'b000};
            hold_b = {h[14:10], 3'b000};
        end
        if (wr_en && in_win(wa)) model[(wa - 12'h200) >> 2] = wd;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 rd_valid"}, 32'(rvld), 32'(e_rv));
        if (e_rv) chk({tag, " R2 rd_data"}, rdata, e_rd);
        chk({tag, " R7 out_valid"}, 32'(ovld), 32'(e_ov));
        if (e_ov) begin
            chk({tag, " R5 red"}, 32'(red), 32'(hold_r));
            chk({tag, " R5 green"}, 32'(grn), 32'(hold_g));
            chk({tag, " R5 blue"}, 32'(blu), 32'(hold_b));
        end
        wr_en = 0; rd_en = 0; pv = 0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset rd_valid", 32'(rvld), 0);
        chk("R1 reset out_valid", 32'(ovld), 0);
        rst_n = 1;
        // R1: every word reads as zero after reset.
        for (int i = 0; i < 128; i++) begin
            rd_en = 1; ra = 12'(12'h200 + 4 * i); step("R1 clear");
        end
        // R2/R4/R5: write words with distinct fields, read back and look up both halves.
        for (int i = 0; i < 8; i++) begin
            wr_en = 1; wa = 12'(12'h200 + 4 * (i * 17 % 128));
            wd = 32'h7c1f_03e0 ^ (32'h1357_9bdf * (i + 1)); step("R2 write");
        end
        for (int i = 0; i < 8; i++) begin
            rd_en = 1; ra = 12'(12'h200 + 4 * (i * 17 % 128));
            pv = 1; pidx = 8'(2 * (i * 17 % 128)); step("R4 even");
            pv = 1; pidx = 8'(2 * (i * 17 % 128) + 1); step("R4 odd");
        end
        // R6: same colour with intensity bit clear and set.
        wr_en = 1; wa = 12'h210; wd = 32'h8000_0000 | 32'h4a52 | (32'h4a52 << 16); step("R6 write");
        pv = 1; pidx = 8'd8; step("R6 clear bit");
        chk("R6 red clear", 32'(red), 32'h90);
        pv = 1; pidx = 8'd9; step("R6 set bit");
        chk("R6 red set", 32'(red), 32'h90);
        chk("R6 green set", 32'(grn), 32'h90);
        chk("R6 blue set", 32'(blu), 32'h90);
        // R3: writes just outside the window leave neighbours untouched; reads give zero.
        wr_en = 1; wa = 12'h1fc; wd = 32'hdead_beef; step("R3 low write");
        wr_en = 1; wa = 12'h400; wd = 32'hcafe_f00d; step("R3 high write");
        rd_en = 1; ra = 12'h200; step("R3 first word");
        rd_en = 1; ra = 12'h3fc; step("R3 last word");
        rd_en = 1; ra = 12'h1fc; step("R3 low read");
        rd_en = 1; ra = 12'h400; step("R3 high read");
        // R8/R9: collision of a write with a lookup and a read of the same word.
        wr_en = 1; wa = 12'h3fc; wd = 32'h1234_5678;
        rd_en = 1; ra = 12'h3fc; pv = 1; pidx = 8'd255; step("R8 R9 collide");
        rd_en = 1; ra = 12'h3fc; pv = 1; pidx = 8'd255; step("R8 R9 after");
        // Mixed traffic on every port.
        for (int i = 0; i < 2000; i++) begin
            wr_en = $urandom_range(0, 1);
            wa = ($urandom_range(0, 9) == 0) ? 12'($urandom_range(0, 4095)) : 12'(12'h200 + 4 * $urandom_range(0, 127));
            wd = $urandom;
            rd_en = $urandom_range(0, 1);
            ra = ($urandom_range(0, 9) == 0) ? 12'($urandom_range(0, 4095)) : 12'(12'h200 + 4 * $urandom_range(0, 127));
            pv = $urandom_range(0, 3) != 0;
            pidx = 8'($urandom_range(0, 255));
            step("R7 R8 R9 mixed");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule